// File: doc/BRIEF.md
# Time-of-Day Alarm Match Unit

This block watches a broken-down BCD time (seconds, minutes, hours, day of month) that a separate timekeeping counter presents, along with a strobe that pulses once per second when that time advances. A host programs four alarm fields over a byte-wide register bus. On each second strobe the unit compares the current time with the alarm fields and, on agreement, latches an alarm flag that can drive an active-low interrupt line.

Each alarm field carries a don't-care bit in its top position. A field with that bit set always agrees, so a host can build alarms such as "every minute at second 30" or "every day at 07:15:00". With all four don't-care bits set, the flag is raised on every second strobe, which gives a once-per-second periodic interrupt. The host reads the flag register to learn that an alarm happened, and that same read clears the flag.

Top module: `tod_alarm_match`

## Requirements
- R1: After reset every alarm register, the flag register and the control register read 0x00, and `irq_n` is high.
- R2: Alarm registers sit at 0x8 (seconds), 0x9 (minutes), 0xA (hours) and 0xB (day of month). A write lands in the register and reads back on the next cycle. Bit 7 is the don't-care bit. Seconds and minutes keep bits 6:0. Hours and day keep bits 5:0, and their bit 6 reads as 0.
- R3: When `tick_1s` is high and every field without its don't-care bit equals the matching time input, bit 0 of the flag register at 0xE reads 1 from the next cycle on.
- R4: A field whose bit 7 is set counts as agreeing whatever the time input holds. A field with bit 7 clear that differs from its time input blocks the flag.
- R5: With bit 7 set in all four alarm registers, every `tick_1s` pulse sets the flag.
- R6: A match while `tick_1s` is low leaves the flag unchanged.
- R7: A read of 0xE returns the flag in bit 0, with bits 7:1 at zero. The flag is clear from the following cycle on.
- R8: When a flag-setting match and a read of 0xE fall in the same cycle, the read returns the old flag and the flag is 1 afterwards.
- R9: Bit 3 of the control register at 0xF is the interrupt enable. `irq_n` is low exactly while the flag and that enable are both 1.
- R10: The control register keeps only bit 3, so a read of 0xF returns bit 3 alone. Reads of unmapped offsets, such as 0x0, return 0x00. Writes to 0xE do not change the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| tick_1s | input | 1 | One-cycle pulse per second of time advance |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, BCD |
| now_date | input | 6 | Current day of month, BCD |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The assertions check these rules on every cycle:
- The flag never rises without a second strobe in the cycle before.
- An all-masked strobe always raises the flag, even when a clearing read falls in the same cycle.
- A clearing read with no strobe leaves the flag low.
- The interrupt line only falls after a strobe or a control write.

The bench scenarios cover the rest:
- The exact compare of each field, including the BCD value widths.
- Readback of stored values.
- The pass-through effect of individual don't-care bits on mixed patterns.
- Unmapped offsets and writes to the flag register, which the bench detects only by comparing read data against its own model.

// File: rtl/tod_alarm_match.sv
module tod_alarm_match #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tick_1s,
  input  logic [6:0]        now_sec,
  input  logic [6:0]        now_min,
  input  logic [5:0]        now_hour,
  input  logic [5:0]        now_date,
  output logic              irq_n
);
  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(11);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(15);
  localparam int TIE_BIT = 3;

  logic       al_sec_m, al_min_m, al_hr_m, al_dt_m;
  logic [6:0] al_sec_v, al_min_v;
  logic [5:0] al_hr_v, al_dt_v;
  logic       flag_q, tie_q;

  wire wr_en = bus_sel & bus_wr;
  wire rd_en = bus_sel & ~bus_wr;

  wire hit = (al_sec_m | (al_sec_v == now_sec)) &
             (al_min_m | (al_min_v == now_min)) &
             (al_hr_m  | (al_hr_v  == now_hour)) &
             (al_dt_m  | (al_dt_v  == now_date));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_sec_m <= 1'b0; al_sec_v <= '0;
      al_min_m <= 1'b0; al_min_v <= '0;
      al_hr_m  <= 1'b0; al_hr_v  <= '0;
      al_dt_m  <= 1'b0; al_dt_v  <= '0;
      tie_q    <= 1'b0;
    end else if (wr_en) begin
      case (bus_addr)
        A_SEC:  begin al_sec_m <= bus_wdata[7]; al_sec_v <= bus_wdata[6:0]; end
        A_MIN:  begin al_min_m <= bus_wdata[7]; al_min_v <= bus_wdata[6:0]; end
        A_HOUR: begin al_hr_m  <= bus_wdata[7]; al_hr_v  <= bus_wdata[5:0]; end
        A_DATE: begin al_dt_m  <= bus_wdata[7]; al_dt_v  <= bus_wdata[5:0]; end
        A_CTRL: tie_q <= bus_wdata[TIE_BIT];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (tick_1s && hit)
      flag_q <= 1'b1;
    else if (rd_en && bus_addr == A_FLAG)
      flag_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = 8'h00;
    case (bus_addr)
      A_SEC:  bus_rdata = {al_sec_m, al_sec_v};
      A_MIN:  bus_rdata = {al_min_m, al_min_v};
      A_HOUR: bus_rdata = {al_hr_m, 1'b0, al_hr_v};
      A_DATE: bus_rdata = {al_dt_m, 1'b0, al_dt_v};
      A_FLAG: bus_rdata = {7'b0, flag_q};
      A_CTRL: bus_rdata[TIE_BIT] = tie_q;
      default: ;
    endcase
  end

  assign irq_n = ~(flag_q & tie_q);
endmodule

// File: rtl/tod_alarm_match_chk.sv
module tod_alarm_match_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_1s,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq_n,
  input logic              flag_q,
  input logic [3:0]        mask_all
);
  wire flag_rd  = bus_sel && !bus_wr && bus_addr == ADDR_W'(14);
  wire ctrl_wr  = bus_sel && bus_wr && bus_addr == ADDR_W'(15);

  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> irq_n);

  assert_flag_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick_1s));

  assert_all_masked_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1s && (&mask_all) |=> flag_q);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd && !tick_1s |=> !flag_q);

  assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd && tick_1s && (&mask_all) |=> flag_q);

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> ($past(tick_1s) || $past(ctrl_wr)));
endmodule

bind tod_alarm_match tod_alarm_match_chk #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .bus_sel(bus_sel),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .irq_n(irq_n), .flag_q(flag_q),
  .mask_all({al_sec_m, al_min_m, al_hr_m, al_dt_m})
);

// File: tb/tod_alarm_match_test.sv
module tod_alarm_match_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, tick_1s = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [6:0] now_sec = 0, now_min = 0;
  logic [5:0] now_hour = 0, now_date = 0;
  logic irq_n;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [7:0] m_al [4];
  logic m_flag = 0, m_tie = 0;

  always #5 clk = ~clk;

  tod_alarm_match #(.ADDR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_1s(tick_1s), .now_sec(now_sec), .now_min(now_min),
    .now_hour(now_hour), .now_date(now_date), .irq_n(irq_n));

  function automatic logic [7:0] keep(int idx, logic [7:0] d);
    return (idx < 2) ? d : (d & 8'hBF);
  endfunction

  function automatic bit fld_ok(logic [7:0] a, logic [6:0] t);
    return a[7] || (a[6:0] == t);
  endfunction

  function automatic logic [7:0] model_read(logic [3:0] a);
    if (a >= 4'h8 && a <= 4'hB) return m_al[a - 4'h8];
    if (a == 4'hE) return {7'b0, m_flag};
    if (a == 4'hF) return {4'b0, m_tie, 3'b0};
    return 8'h00;
  endfunction

  task automatic chk(logic [7:0] act, logic [7:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit sel, bit wr, logic [3:0] a, logic [7:0] d, bit tk,
                      logic [6:0] s, logic [6:0] mi, logic [5:0] h, logic [5:0] dt,
                      string tag);
    bit hit;
    @(negedge clk);
    chk({7'b0, irq_n}, {7'b0, !(m_flag && m_tie)}, "R9 irq_n");
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d; tick_1s = tk;
    now_sec = s; now_min = mi; now_hour = h; now_date = dt;
    #1;
    if (sel && !wr) chk(bus_rdata, model_read(a), tag);
    hit = tk && fld_ok(m_al[0], s) && fld_ok(m_al[1], mi) &&
          fld_ok(m_al[2], {1'b0, h}) && fld_ok(m_al[3], {1'b0, dt});
    if (sel && wr) begin
      if (a >= 4'h8 && a <= 4'hB) m_al[a - 4'h8] = keep(int'(a - 4'h8), d);
      if (a == 4'hF) m_tie = d[3];
    end
    if (hit) m_flag = 1'b1;
    else if (sel && !wr && a == 4'hE) m_flag = 1'b0;
  endtask

  task automatic wr_reg(logic [3:0] a, logic [7:0] d);
    step(1, 1, a, d, 0, 0, 0, 0, 0, "");
  endtask
  task automatic rd_reg(logic [3:0] a, string tag);
    step(1, 0, a, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic tick(logic [6:0] s, logic [6:0] mi, logic [5:0] h, logic [5:0] dt);
    step(0, 0, 0, 0, 1, s, mi, h, dt, "");
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    for (int i = 0; i < 4; i++) m_al[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk({7'b0, irq_n}, 8'h01, "R1 irq_n in reset");
    rst_n = 1'b1;
    for (int a = 8; a < 16; a++) rd_reg(4'(a), "R1 reset value");

    wr_reg(4'h8, 8'hFF); rd_reg(4'h8, "R2 seconds keep");
    wr_reg(4'hA, 8'hFF); rd_reg(4'hA, "R2 hours bit6 zero");
    wr_reg(4'hB, 8'h7F); rd_reg(4'hB, "R2 date bit6 zero");
    wr_reg(4'h9, 8'h59); rd_reg(4'h9, "R2 minutes keep");

    wr_reg(4'hF, 8'hFF); rd_reg(4'hF, "R10 control only enable");
    rd_reg(4'h0, "R10 unmapped reads zero");
    wr_reg(4'hF, 8'h08);

    wr_reg(4'h8, 8'h30); wr_reg(4'h9, 8'h15);
    wr_reg(4'hA, 8'h12); wr_reg(4'hB, 8'h07);
    step(0, 0, 0, 0, 0, 7'h30, 7'h15, 6'h12, 6'h07, "");
    rd_reg(4'hE, "R6 match without tick");
    tick(7'h30, 7'h15, 6'h12, 6'h07);
    rd_reg(4'hE, "R3 exact match sets flag");
    rd_reg(4'hE, "R7 flag cleared by read");
    tick(7'h31, 7'h15, 6'h12, 6'h07);
    rd_reg(4'hE, "R4 unmasked mismatch blocks");
    tick(7'h30, 7'h15, 6'h12, 6'h07);
    wr_reg(4'hE, 8'h00);
    rd_reg(4'hE, "R10 write to flag ignored");
    wr_reg(4'h8, 8'h80);
    tick(7'h44, 7'h15, 6'h12, 6'h07);
    rd_reg(4'hE, "R4 masked seconds agree");
    wr_reg(4'h9, 8'h80); wr_reg(4'hA, 8'h80); wr_reg(4'hB, 8'h80);
    for (int k = 0; k < 3; k++) begin
      tick(7'($urandom % 60), 7'($urandom % 60), 6'($urandom % 24), 6'($urandom % 32));
      rd_reg(4'hE, "R5 all masked fires each tick");
    end
    step(1, 0, 4'hE, 0, 1, 7'h01, 7'h02, 6'h03, 6'h04, "R8 read returns old flag");
    rd_reg(4'hE, "R8 set wins over clear");
    tick(0, 0, 0, 0);
    wr_reg(4'hF, 8'h00);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    rd_reg(4'hE, "R9 flag held while enable off");
    wr_reg(4'hF, 8'h08);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "");

    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [7:0] v;
      op = $urandom % 8;
      v = {($urandom % 4) == 0, 7'($urandom % 2)};
      case (op)
        0, 1: wr_reg(4'(8 + ($urandom % 4)), v);
        2: rd_reg(4'(8 + ($urandom % 4)), "R2 random readback");
        3: rd_reg(4'hE, "R7 random flag read");
        4: wr_reg(4'hF, 8'($urandom));
        5: step(1, 0, 4'hE, 0, 1, 7'($urandom % 2), 7'($urandom % 2),
                6'($urandom % 2), 6'($urandom % 2), "R8 random read with tick");
        default: tick(7'($urandom % 2), 7'($urandom % 2),
                      6'($urandom % 2), 6'($urandom % 2));
      endcase
    end
    rd_reg(4'hE, "R3 final flag");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule